// File: doc/BRIEF.md
# Time-Multiplexed Fuzzy Rule Weight Decoder

This block produces the firing weights for a bank of fuzzy rules in a two-input, one-output fuzzy controller. Each input arrives already fuzzified as a trapezoid described by four breakpoints. Each rule carries one trapezoidal antecedent per input. For one input, the matching degree is the height of the highest point where the input trapezoid and the rule's antecedent trapezoid overlap. The rule weight is the smaller of the two matching degrees.

Two matching units run side by side, one for each input. A single pair of these units is shared across the rules in the bank. A rule-select multiplexer feeds them one rule at a time, and each rule takes two clock cycles. In the first cycle the unit classifies the overlap and registers the operands of the crossover. In the second cycle it divides, takes the minimum, and a select-decoded write stores the weight in that rule's register. A bank of 16 rules is served by instantiating four of these decoders in parallel. At any moment each instance works on the rule in the same slot, so rules 4i are handled together in the first two cycles, rules 4i+1 in the next two, and so on.

Top module: `fz_rule_decoder`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every weight register holds 0.
- R2: A matching degree is 0 when the trapezoids do not overlap: the antecedent's last breakpoint is at or below the input's first, or the input's last breakpoint is at or below the antecedent's first. Touching end points count as no overlap.
- R3: When the two trapezoids overlap and their plateaus (breakpoint 1 to breakpoint 2) intersect, identical shapes included, the matching degree is the full grade, which is 15 for 4-bit grades.
- R4: Crossover with the input to the right of the antecedent. This case applies when the antecedent's breakpoint 2 is below the input's breakpoint 1. The degree is floor(15·(a3−x0) / ((a3−a2)+(x1−x0))), where a is the antecedent and x is the input.
- R5: Crossover with the input to the left of the antecedent. The degree is floor(15·(x3−a0) / ((x3−x2)+(a1−a0))).
- R6: The weight of a rule is the minimum of its degree against input A and its degree against input B.
- R7: A start accepted while idle raises `busy` for exactly 2·N_RULES cycles. Rule k is evaluated in cycles 2k and 2k+1 of the run. `done` is seen 2·N_RULES cycles after the accepting edge.
- R8: `done` is high for exactly one cycle per run.
- R9: `start` is ignored while `busy` is high. The run is neither restarted nor extended, and no extra `done` follows.
- R10: While idle, the weight outputs hold their values, even when the inputs or antecedents change.
- R11: Weight slot k, at bits [4k+3:4k], always holds the weight of rule k, taken from bits [24k+23:24k] of each antecedent bus. Within a trapezoid, breakpoint j sits at bits [6j+5:6j], with j=0 the leftmost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run over all rules; honoured only when idle |
| in_a | input | 24 | Fuzzified input A, four 6-bit breakpoints |
| in_b | input | 24 | Fuzzified input B, four 6-bit breakpoints |
| ant_a | input | 96 | Input-A antecedents of rules 0..3, 24 bits each |
| ant_b | input | 96 | Input-B antecedents of rules 0..3, 24 bits each |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle strobe after the last weight is written |
| weights | output | 16 | Four registered 4-bit rule weights |

## Verification
Some properties hold on every cycle, and the assertions check these. `busy` lasts exactly 2·N_RULES cycles. `done` is a one-cycle pulse that follows a busy cycle. An idle start is always accepted. The weight outputs never move while the block is idle.

The arithmetic can only be shown by the bench's scenarios. This covers the no-overlap, plateau and two crossover cases, the minimum of the two degrees, and the slot ordering that ties each weight to its own rule. The bench also shows that a start arriving mid-run does not shift the `done` strobe.

// File: rtl/fz_pkg.sv
package fz_pkg;
   // Overlap classification produced in the first half of a rule slot
   typedef enum logic [1:0] {
      MD_NONE  = 2'd0,
      MD_FULL  = 2'd1,
      MD_CROSS = 2'd2
   } md_kind_e;
endpackage

// File: rtl/fz_match_deg.sv
module fz_match_deg
   import fz_pkg::*;
#(
   parameter int PT_W    = 6,
   parameter int GRADE_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cap_en,
   input  logic [4*PT_W-1:0]    ant,
   input  logic [4*PT_W-1:0]    fin,
   output logic [GRADE_W-1:0]   grade
);
   localparam int DEN_W  = PT_W + 1;
   localparam int PROD_W = GRADE_W + PT_W;
   localparam logic [GRADE_W-1:0] G_MAX = '1;

   logic [PT_W-1:0] a [4];
   logic [PT_W-1:0] x [4];

   for (genvar j = 0; j < 4; j++) begin : g_unpack
      assign a[j] = ant[j*PT_W +: PT_W];
      assign x[j] = fin[j*PT_W +: PT_W];
   end

   // phase 1: classify the overlap and form crossover operands
   md_kind_e         kind_d, kind_q;
   logic [PT_W-1:0]  num_d, num_q;
   logic [DEN_W-1:0] den_d, den_q;
   logic [PT_W-1:0]  slope_1, slope_2;

   always_comb begin
      kind_d  = MD_NONE;
      num_d   = '0;
      den_d   = '0;
      slope_1 = '0;
      slope_2 = '0;
      if ((a[3] <= x[0]) || (x[3] <= a[0])) begin
         kind_d = MD_NONE;
      end else if ((a[1] <= x[2]) && (x[1] <= a[2])) begin
         kind_d = MD_FULL;
      end else if (a[2] < x[1]) begin
         kind_d  = MD_CROSS;
         num_d   = a[3] - x[0];
         slope_1 = a[3] - a[2];
         slope_2 = x[1] - x[0];
         den_d   = {1'b0, slope_1} + {1'b0, slope_2};
      end else begin
         kind_d  = MD_CROSS;
         num_d   = x[3] - a[0];
         slope_1 = x[3] - x[2];
         slope_2 = a[1] - a[0];
         den_d   = {1'b0, slope_1} + {1'b0, slope_2};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= MD_NONE;
         num_q  <= '0;
         den_q  <= '0;
      end else if (cap_en) begin
         kind_q <= kind_d;
         num_q  <= num_d;
         den_q  <= den_d;
      end
   end

   // phase 2: scale and divide to a grade
   logic [PROD_W-1:0] prod, quo;

   always_comb begin
      prod = PROD_W'(G_MAX) * PROD_W'(num_q);
      quo  = (den_q == '0) ? '0 : prod / PROD_W'(den_q);
      case (kind_q)
         MD_FULL:  grade = G_MAX;
         MD_CROSS: grade = quo[GRADE_W-1:0];
         default:  grade = '0;
      endcase
   end
endmodule

// File: rtl/fz_seq.sv
module fz_seq #(
   parameter int N_RULES = 4,
   localparam int SEL_W  = $clog2(N_RULES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic [SEL_W-1:0] sel,
   output logic             cap_en,
   output logic             wr_en
);
   localparam int CNT_W = SEL_W + 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(2*N_RULES - 1);

   logic [CNT_W-1:0] cnt;

   assign sel    = cnt[CNT_W-1:1];
   assign cap_en = busy & ~cnt[0];
   assign wr_en  = busy &  cnt[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               cnt  <= '0;
            end
         end else begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fz_weight_store.sv
module fz_weight_store #(
   parameter int N_RULES = 4,
   parameter int GRADE_W = 4,
   localparam int SEL_W  = $clog2(N_RULES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [SEL_W-1:0]             sel,
   input  logic [GRADE_W-1:0]           wdata,
   output logic [N_RULES*GRADE_W-1:0]   weights
);
   for (genvar k = 0; k < N_RULES; k++) begin : g_slot
      logic [GRADE_W-1:0] w_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            w_q <= '0;
         else if (wr_en && (sel == SEL_W'(k)))
            w_q <= wdata;
      end
      assign weights[k*GRADE_W +: GRADE_W] = w_q;
   end
endmodule

// File: rtl/fz_rule_decoder.sv
module fz_rule_decoder #(
   parameter int N_RULES = 4,
   parameter int PT_W    = 6,
   parameter int GRADE_W = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [4*PT_W-1:0]            in_a,
   input  logic [4*PT_W-1:0]            in_b,
   input  logic [N_RULES*4*PT_W-1:0]    ant_a,
   input  logic [N_RULES*4*PT_W-1:0]    ant_b,
   output logic                         busy,
   output logic                         done,
   output logic [N_RULES*GRADE_W-1:0]   weights
);
   localparam int SEL_W  = $clog2(N_RULES);
   localparam int TRAP_W = 4 * PT_W;

   if (N_RULES < 2 || (N_RULES & (N_RULES - 1)) != 0) begin : g_bad_rules
      $error("N_RULES must be a power of two of at least 2");
   end
   if (PT_W < 2 || GRADE_W < 1) begin : g_bad_width
      $error("PT_W must be at least 2 and GRADE_W at least 1");
   end

   logic [SEL_W-1:0]   sel;
   logic               cap_en, wr_en;
   logic [TRAP_W-1:0]  ant_sel [2];
   logic [TRAP_W-1:0]  fin     [2];
   logic [GRADE_W-1:0] deg     [2];
   logic [GRADE_W-1:0] w_min;

   fz_seq #(.N_RULES(N_RULES)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .busy   (busy),
      .done   (done),
      .sel    (sel),
      .cap_en (cap_en),
      .wr_en  (wr_en)
   );

   // rule multiplexers, one per input variable
   assign ant_sel[0] = ant_a[sel*TRAP_W +: TRAP_W];
   assign ant_sel[1] = ant_b[sel*TRAP_W +: TRAP_W];
   assign fin[0]     = in_a;
   assign fin[1]     = in_b;

   for (genvar v = 0; v < 2; v++) begin : g_match
      fz_match_deg #(.PT_W(PT_W), .GRADE_W(GRADE_W)) u_md (
         .clk    (clk),
         .rst_n  (rst_n),
         .cap_en (cap_en),
         .ant    (ant_sel[v]),
         .fin    (fin[v]),
         .grade  (deg[v])
      );
   end

   assign w_min = (deg[0] < deg[1]) ? deg[0] : deg[1];

   fz_weight_store #(.N_RULES(N_RULES), .GRADE_W(GRADE_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .sel     (sel),
      .wdata   (w_min),
      .weights (weights)
   );
endmodule

// File: rtl/fz_rule_decoder_chk.sv
module fz_rule_decoder_chk #(
   parameter int N_RULES = 4,
   parameter int GRADE_W = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         start,
   input logic                         busy,
   input logic                         done,
   input logic [N_RULES*GRADE_W-1:0]   weights
);
   localparam int BC_W = $clog2(2*N_RULES) + 1;
   localparam logic [BC_W-1:0] RUN_LEN = BC_W'(2*N_RULES);

   logic [BC_W-1:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         busy_cnt <= '0;
      else if (busy)
         busy_cnt <= busy_cnt + 1'b1;
      else
         busy_cnt <= '0;
   end

   // R7
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && busy_cnt == RUN_LEN - 1'b1) |=> !busy);

   // R7
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_cnt < RUN_LEN));

   // R7
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(weights));
endmodule

bind fz_rule_decoder fz_rule_decoder_chk #(
   .N_RULES (N_RULES),
   .GRADE_W (GRADE_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .weights (weights)
);

// File: tb/fz_rule_decoder_tb.sv
module fz_rule_decoder_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NR = 4;
   localparam int PW = 6;
   localparam int GW = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [4*PW-1:0]   in_a = '0, in_b = '0;
   logic [NR*4*PW-1:0] ant_a = '0, ant_b = '0;
   logic              busy, done;
   logic [NR*GW-1:0]  weights;

   int n_chk = 0;
   int n_bad = 0;
   int unsigned seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   fz_rule_decoder #(.N_RULES(NR), .PT_W(PW), .GRADE_W(GW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .in_a(in_a), .in_b(in_b), .ant_a(ant_a), .ant_b(ant_b),
      .busy(busy), .done(done), .weights(weights)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [4*PW-1:0] trap(input int p0, input int p1,
                                             input int p2, input int p3);
      return {PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
   endfunction

   function automatic int pt(input logic [4*PW-1:0] t, input int j);
      return int'(t[j*PW +: PW]);
   endfunction

   // matching degree from R2..R5
   function automatic int md_ref(input logic [4*PW-1:0] an, input logic [4*PW-1:0] xi);
      int a0 = pt(an,0), a1 = pt(an,1), a2 = pt(an,2), a3 = pt(an,3);
      int x0 = pt(xi,0), x1 = pt(xi,1), x2 = pt(xi,2), x3 = pt(xi,3);
      if (a3 <= x0 || x3 <= a0) return 0;
      if (a1 <= x2 && x1 <= a2) return 15;
      if (a2 < x1) return (15*(a3-x0)) / ((a3-a2)+(x1-x0));
      return (15*(x3-a0)) / ((x3-x2)+(a1-a0));
   endfunction

   function automatic int w_of(input int k);
      return int'(weights[k*GW +: GW]);
   endfunction

   function automatic int exp_w(input int k);
      int da = md_ref(ant_a[k*4*PW +: 4*PW], in_a);
      int db = md_ref(ant_b[k*4*PW +: 4*PW], in_b);
      return (da < db) ? da : db;
   endfunction

   // one run: pulse start, measure latency to done (R7), check pulse width (R8)
   task automatic run_op(input string tag);
      int lat = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk({tag, " R7 busy after start"}, int'(busy), 1);
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      chk({tag, " R7 done latency"}, lat, 2*NR);
      @(negedge clk);
      chk({tag, " R8 done one cycle"}, int'(done), 0);
      chk({tag, " R7 idle after run"}, int'(busy), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 weights", int'(weights), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_overlap_cases();
      // every rule shares input-B antecedent equal to in_b -> degree 15 (R3)
      in_b = trap(5, 10, 20, 30);
      for (int k = 0; k < NR; k++) ant_b[k*4*PW +: 4*PW] = in_b;
      in_a = trap(10, 20, 24, 30);
      ant_a[0*4*PW +: 4*PW] = trap(0, 2, 4, 6);     // disjoint
      ant_a[1*4*PW +: 4*PW] = trap(0, 2, 4, 10);    // touching end
      ant_a[2*4*PW +: 4*PW] = trap(0, 4, 8, 16);    // right crossover -> 5
      ant_a[3*4*PW +: 4*PW] = trap(22, 23, 26, 40); // plateaus meet -> 15
      run_op("overlap");
      chk("R2 disjoint", w_of(0), 0);
      chk("R2 touching", w_of(1), 0);
      chk("R4 right crossover", w_of(2), 5);
      chk("R3 plateau overlap", w_of(3), 15);
   endtask

   task automatic t_left_and_min();
      in_a = trap(0, 5, 10, 26);
      in_b = trap(30, 31, 32, 33);
      ant_a[0*4*PW +: 4*PW] = trap(20, 30, 40, 50); // left crossover -> 3
      ant_b[0*4*PW +: 4*PW] = trap(30, 31, 32, 33); // 15
      ant_a[1*4*PW +: 4*PW] = in_a;                 // 15
      ant_b[1*4*PW +: 4*PW] = trap(0, 20, 25, 34);  // right: 15*4/(9+1)=6
      ant_a[2*4*PW +: 4*PW] = in_a;                 // 15
      ant_b[2*4*PW +: 4*PW] = trap(40, 41, 42, 43); // 0
      ant_a[3*4*PW +: 4*PW] = trap(20, 30, 40, 50); // 3
      ant_b[3*4*PW +: 4*PW] = trap(0, 20, 25, 34);  // 6
      run_op("leftmin");
      chk("R5 left crossover", w_of(0), 3);
      chk("R6 min picks B", w_of(1), 6);
      chk("R6 min zero", w_of(2), 0);
      chk("R6 min picks A", w_of(3), 3);
   endtask

   task automatic t_order();
      // identical inputs, rules crafted to distinct weights (R11)
      in_a = trap(10, 20, 24, 30);
      in_b = in_a;
      ant_a[0*4*PW +: 4*PW] = in_a;                 // 15
      ant_a[1*4*PW +: 4*PW] = trap(0, 4, 8, 16);    // 5
      ant_a[2*4*PW +: 4*PW] = trap(0, 2, 4, 6);     // 0
      ant_a[3*4*PW +: 4*PW] = trap(0, 4, 8, 20);    // 15*10/22=6
      for (int k = 0; k < NR; k++) ant_b[k*4*PW +: 4*PW] = in_b;
      run_op("order");
      chk("R11 slot0", w_of(0), 15);
      chk("R11 slot1", w_of(1), 5);
      chk("R11 slot2", w_of(2), 0);
      chk("R11 slot3", w_of(3), 6);
   endtask

   task automatic t_busy_start();
      int lat = 0;
      int extra = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (3) @(negedge clk);
      lat = 3;
      start = 1'b1;                 // ignored while busy (R9)
      @(negedge clk) start = 1'b0;
      lat++;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      chk("R9 latency unchanged", lat, 2*NR);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (done || busy) extra++;
      end
      chk("R9 no second run", extra, 0);
      chk("R9 weights intact", w_of(3), 6);
   endtask

   task automatic t_hold();
      logic [NR*GW-1:0] snap = weights;
      ant_a = '0;
      ant_b = {NR{trap(1, 2, 3, 4)}};
      in_a = trap(50, 55, 60, 63);
      repeat (6) @(negedge clk);
      chk("R10 weights held idle", int'(weights), int'(snap));
   endtask

   function automatic logic [4*PW-1:0] rnd_trap();
      int v[4];
      for (int i = 0; i < 4; i++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         v[i] = int'(seed[21:16]);
      end
      for (int i = 0; i < 3; i++)
         for (int j = 0; j < 3 - i; j++)
            if (v[j] > v[j+1]) begin
               int t = v[j]; v[j] = v[j+1]; v[j+1] = t;
            end
      return trap(v[0], v[1], v[2], v[3]);
   endfunction

   task automatic t_sweep();
      for (int r = 0; r < 25; r++) begin
         in_a = rnd_trap();
         in_b = rnd_trap();
         for (int k = 0; k < NR; k++) begin
            ant_a[k*4*PW +: 4*PW] = rnd_trap();
            ant_b[k*4*PW +: 4*PW] = rnd_trap();
         end
         run_op("sweep");
         for (int k = 0; k < NR; k++)
            chk("R6 R11 sweep weight", w_of(k), exp_w(k));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_overlap_cases();
      t_left_and_min();
      t_order();
      t_busy_start();
      t_hold();
      t_sweep();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule